// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block is a per-core watchdog that climbs one step up an escalation ladder each time its timeout period runs out without being serviced. When the first unserviced period ends, the interrupt line rises. When a second period ends, the non-maskable interrupt line rises. When a third period ends, a one-cycle chip soft-reset request goes out. Software services the watchdog by writing a poke. The poke reloads the count and drops the ladder back to idle.

The period comes from a LEN field of `LEN_W` bits. LEN is loaded into the upper bits of a down-counter whose `LOW_W` low bits start at zero. That counter steps once every 2^`PRESC_W` clocks. One period is therefore exactly LEN × 2^(`LOW_W`+`PRESC_W`) clocks. With the default parameters this is LEN × 65536. A two-bit mode field caps how far the ladder may climb. The current stage is always visible on a two-bit state output.

Top module: `esc_wdog`

## Requirements
- R1: After reset, the state output is 0 and the interrupt, NMI and soft-reset outputs are low. No escalation happens until a configuration is written.
- R2: A configuration write takes config data bits [1:0] as the mode and bits [LEN_W+1:2] as LEN. The first expiry moves the state from 0 to 1 on the clock edge exactly LEN × 2^(LOW_W+PRESC_W) cycles after the write edge. Before that edge the state is still 0.
- R3: Each further unserviced period advances the state by exactly one, at multiples of the period after the start edge. The order is 1 (interrupt), then 2 (NMI), then 3 (reset).
- R4: The mode caps the highest reachable stage. Mode 1 stops at stage 1, mode 2 stops at stage 2, and mode 3 allows all three stages.
- R5: The soft-reset request is high for exactly one cycle, the cycle in which the state first becomes 3. Counting then halts, so the request is never repeated until a poke or a configuration write.
- R6: The interrupt output is a level that is high whenever the state is 1 or more. The NMI output is a level that is high whenever the state is 2 or more. Both stay high until a poke or a configuration write.
- R7: A poke write (select = 1) with data bit 0 set returns the state to 0 and lowers the interrupt and NMI outputs. It restarts the prescaler and the counter, so the next expiry is one full period after the poke edge.
- R8: A poke write with data bit 0 clear has no effect on the state or the outputs.
- R9: Writing an all-zero configuration disables the watchdog, and the state stays 0. A configuration with LEN = 0 is also treated as disabled, whatever its mode.
- R10: A configuration write while the watchdog is escalating returns the state to 0. It restarts the prescaler and the counter from the newly written LEN.
- R11: State encoding: 0 = idle, 1 = interrupt, 2 = NMI, 3 = reset. Bit 1 of the state is set exactly when the NMI stage has been reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | 0 = configuration register, 1 = poke register |
| wr_data | input | LEN_W+2 | Write data: mode in [1:0], LEN in [LEN_W+1:2]; poke uses bit 0 |
| state_o | output | 2 | Current escalation stage |
| irq_o | output | 1 | Interrupt level (stage 1 or more) |
| nmi_o | output | 1 | Non-maskable interrupt level (stage 2 or more) |
| srst_o | output | 1 | One-cycle soft-reset request |

## Verification
Call the clock edge that samples a configuration write or poke edge 0, and let one period be D = LEN × 2^(LOW_W+PRESC_W) cycles. Stage n is then due on edge n·D. The soft-reset pulse is due only in the cycle that follows edge 3·D. A poke or configuration write takes effect on its own sampling edge. The bench counts falling edges from the write edge. It checks every output at each falling edge across whole sweeps of LEN and mode. Every sample is therefore taken a half cycle after the edge that is supposed to move it, and the cycles just before and just after each expiry are covered.

// File: rtl/esc_wdog_pkg.sv
package esc_wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IRQ  = 2'd1,
        ST_NMI  = 2'd2,
        ST_RST  = 2'd3
    } stage_e;

    typedef enum logic [1:0] {
        MD_OFF  = 2'd0,
        MD_IRQ  = 2'd1,
        MD_NMI  = 2'd2,
        MD_FULL = 2'd3
    } mode_e;

    typedef enum logic {
        SEL_CFG  = 1'b0,
        SEL_POKE = 1'b1
    } sel_e;

    typedef struct packed {
        stage_e stage;
        logic   irq;
        logic   nmi;
        logic   srst;
    } ladder_t;

    // Mode value equals the highest stage it permits.
    function automatic stage_e escalate(stage_e cur, mode_e cap);
        if (cur == ST_RST) return ST_RST;
        if (2'(cur) < 2'(cap)) return stage_e'(2'(cur) + 2'd1);
        return cur;
    endfunction

    function automatic ladder_t ladder_of(stage_e nxt, stage_e cur);
        ladder_t l;
        l.stage = nxt;
        l.irq   = (nxt != ST_IDLE);
        l.nmi   = (nxt == ST_NMI) || (nxt == ST_RST);
        l.srst  = (nxt == ST_RST) && (cur != ST_RST);
        return l;
    endfunction

endpackage

// File: rtl/esc_wdog_regs.sv
module esc_wdog_regs
    import esc_wdog_pkg::*;
#(
    parameter int LEN_W = 16,
    localparam int CFG_W = LEN_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    output mode_e            mode_q,
    output logic [LEN_W-1:0] reload_len,
    output logic             restart,
    output logic             enable
);

    logic [LEN_W-1:0] len_q;
    logic             cfg_wr;
    logic             poke_wr;

    always_comb begin
        cfg_wr     = wr_en && (sel_e'(wr_sel) == SEL_CFG);
        poke_wr    = wr_en && (sel_e'(wr_sel) == SEL_POKE) && wr_data[0];
        restart    = cfg_wr || poke_wr;
        // A configuration write reloads from the value being written.
        reload_len = cfg_wr ? wr_data[CFG_W-1:2] : len_q;
        enable     = (mode_q != MD_OFF) && (len_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_OFF;
            len_q  <= '0;
        end else if (cfg_wr) begin
            mode_q <= mode_e'(wr_data[1:0]);
            len_q  <= wr_data[CFG_W-1:2];
        end
    end

endmodule

// File: rtl/esc_wdog_presc.sv
module esc_wdog_presc #(
    parameter int PRESC_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);

    generate
        if (PRESC_W > 0) begin : g_div
            logic [PRESC_W-1:0] div_q;

            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    div_q <= '0;
                end else if (run) begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick = run && (&div_q);
        end else begin : g_bypass
            logic unused_ok;
            assign unused_ok = clk ^ rst ^ restart;
            assign tick      = run;
        end
    endgenerate

endmodule

// File: rtl/esc_wdog_cnt.sv
module esc_wdog_cnt #(
    parameter int LEN_W = 16,
    parameter int LOW_W = 8,
    localparam int CNT_W = LEN_W + LOW_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [LEN_W-1:0] reload_len,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_val;

    always_comb begin
        reload_val = CNT_W'(reload_len) << LOW_W;
        // Expiry on the step that would reach zero gives an exact period.
        expire     = tick && (cnt_q == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= reload_val;
        end else if (tick) begin
            if (cnt_q == CNT_W'(1)) begin
                cnt_q <= reload_val;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/esc_wdog_stage.sv
module esc_wdog_stage
    import esc_wdog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  logic   expire,
    input  mode_e  mode_q,
    output stage_e stage_q,
    output logic   irq_q,
    output logic   nmi_q,
    output logic   srst_q
);

    ladder_t nxt;

    always_comb begin
        nxt = ladder_of(escalate(stage_q, mode_q), stage_q);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            stage_q <= ST_IDLE;
            irq_q   <= 1'b0;
            nmi_q   <= 1'b0;
            srst_q  <= 1'b0;
        end else if (expire) begin
            stage_q <= nxt.stage;
            irq_q   <= nxt.irq;
            nmi_q   <= nxt.nmi;
            srst_q  <= nxt.srst;
        end else begin
            srst_q  <= 1'b0;
        end
    end

endmodule

// File: rtl/esc_wdog.sv
module esc_wdog
    import esc_wdog_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int LOW_W   = 8,
    parameter int PRESC_W = 8,
    localparam int CFG_W  = LEN_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    output logic [1:0]       state_o,
    output logic             irq_o,
    output logic             nmi_o,
    output logic             srst_o
);

    mode_e            mode_q;
    logic [LEN_W-1:0] reload_len;
    logic             restart;
    logic             enable;
    logic             run;
    logic             tick;
    logic             expire;
    stage_e           stage_q;

    esc_wdog_regs #(.LEN_W(LEN_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .mode_q     (mode_q),
        .reload_len (reload_len),
        .restart    (restart),
        .enable     (enable)
    );

    // The timebase freezes once the reset stage is reached.
    assign run = enable && (stage_q != ST_RST);

    esc_wdog_presc #(.PRESC_W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (run),
        .tick    (tick)
    );

    esc_wdog_cnt #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .tick       (tick),
        .reload_len (reload_len),
        .expire     (expire)
    );

    esc_wdog_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .expire  (expire),
        .mode_q  (mode_q),
        .stage_q (stage_q),
        .irq_q   (irq_o),
        .nmi_q   (nmi_o),
        .srst_q  (srst_o)
    );

    assign state_o = 2'(stage_q);

endmodule

// File: rtl/esc_wdog_chk.sv
module esc_wdog_chk #(
    parameter int CFG_W = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [CFG_W-1:0] wr_data,
    input logic [1:0]       mode_q,
    input logic [1:0]       state_o,
    input logic             irq_o,
    input logic             nmi_o,
    input logic             srst_o
);

    AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        srst_o |=> !srst_o); // R5

    AST_SRST_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        srst_o |-> (state_o == 2'd3)); // R5

    AST_NMI_HOLDS_IRQ: assert property (@(posedge clk) disable iff (rst)
        nmi_o |-> irq_o); // R6

    AST_IRQ_MATCHES_STATE: assert property (@(posedge clk) disable iff (rst)
        irq_o == (state_o != 2'd0)); // R6

    AST_BIT1_IS_NMI: assert property (@(posedge clk) disable iff (rst)
        state_o[1] == nmi_o); // R11

    AST_POKE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && wr_data[0]) |=> (state_o == 2'd0 && !irq_o && !nmi_o)); // R7

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_o != $past(state_o)) |-> (state_o == 2'd0 || state_o == $past(state_o) + 2'd1)); // R3

    AST_MODE_CAP: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd1) |-> !nmi_o); // R4

    AST_ZERO_CFG_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && wr_data == '0) |=> (state_o == 2'd0)); // R9

endmodule

bind esc_wdog esc_wdog_chk #(.CFG_W(CFG_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .mode_q  (mode_q),
    .state_o (state_o),
    .irq_o   (irq_o),
    .nmi_o   (nmi_o),
    .srst_o  (srst_o)
);

// File: tb/esc_wdog_tb.sv
`timescale 1ns/1ps
module esc_wdog_tb;

    localparam int LEN_W   = 4;
    localparam int LOW_W   = 2;
    localparam int PRESC_W = 2;
    localparam int CFG_W   = LEN_W + 2;
    localparam int UNIT    = 1 << (LOW_W + PRESC_W);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic             wr_sel = 1'b0;
    logic [CFG_W-1:0] wr_data = '0;
    logic [1:0]       state_o;
    logic             irq_o, nmi_o, srst_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    esc_wdog #(.LEN_W(LEN_W), .LOW_W(LOW_W), .PRESC_W(PRESC_W)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .state_o (state_o),
        .irq_o   (irq_o),
        .nmi_o   (nmi_o),
        .srst_o  (srst_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Returns at the falling edge following the sampling edge (k = 0).
    task automatic write_reg(input logic sel, input logic [CFG_W-1:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    function automatic int exp_state(int k, int len, int mode);
        int n;
        if (mode == 0 || len == 0) return 0;
        n = k / (len * UNIT);
        return (n < mode) ? n : mode;
    endfunction

    // Checks every output at each falling edge from k = 0 to kmax.
    task automatic sweep(input int len, input int mode, input int kmax, input string base);
        int d;
        d = len * UNIT;
        for (int k = 0; k <= kmax; k++) begin
            int es;
            bit ers;
            string st;
            if (k > 0) @(negedge clk);
            es  = exp_state(k, len, mode);
            ers = (mode == 3) && (len != 0) && (k == 3 * d);
            if (len == 0 || mode == 0) st = "R9";
            else if (k <= d) st = "R2";
            else if (mode < 3 && k >= mode * d) st = "R4";
            else st = "R3";
            chk(int'(state_o) == es, {base, " ", st, " state"}, int'(state_o), es);
            chk(state_o[1] == (es >= 2), {base, " R11 bit1"}, int'(state_o[1]), int'(es >= 2));
            chk(irq_o == (es >= 1), {base, " R6 irq"}, int'(irq_o), int'(es >= 1));
            chk(nmi_o == (es >= 2), {base, " R6 nmi"}, int'(nmi_o), int'(es >= 2));
            chk(srst_o == ers, {base, " R5 srst"}, int'(srst_o), int'(ers));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: quiet after reset with no configuration
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(state_o == 2'd0 && !irq_o && !nmi_o && !srst_o, "R1 reset quiet",
                int'({state_o, irq_o, nmi_o, srst_o}), 0);
        end

        // R2 R3 R4 R5: sweep every mode and every nonzero LEN
        for (int mode = 1; mode <= 3; mode++) begin
            for (int len = 1; len < (1 << LEN_W); len++) begin
                write_reg(1'b0, CFG_W'((len << 2) | mode));
                sweep(len, mode, 4 * len * UNIT + 2, "sweep");
            end
        end

        // R8 then R7: ignored poke, then a real poke mid-escalation
        write_reg(1'b0, CFG_W'((3 << 2) | 3));
        repeat (3 * UNIT + 5) @(negedge clk);
        chk(state_o == 2'd1, "R7 pre-poke state", int'(state_o), 1);
        write_reg(1'b1, CFG_W'(2));
        chk(state_o == 2'd1 && irq_o, "R8 bit0 clear ignored", int'(state_o), 1);
        write_reg(1'b1, CFG_W'(1));
        sweep(3, 3, 4 * 3 * UNIT + 2, "R7 poke");

        // R10: new configuration while at NMI stage
        write_reg(1'b0, CFG_W'((2 << 2) | 2));
        repeat (2 * 2 * UNIT + 3) @(negedge clk);
        chk(state_o == 2'd2, "R10 pre-write state", int'(state_o), 2);
        write_reg(1'b0, CFG_W'((5 << 2) | 3));
        sweep(5, 3, 4 * 5 * UNIT + 2, "R10 rewrite");

        // R9: disabling configurations from the reset stage
        write_reg(1'b0, '0);
        sweep(0, 0, 4 * 2 * UNIT, "R9 zero cfg");
        write_reg(1'b0, CFG_W'((4 << 2) | 0));
        sweep(4, 0, 4 * 4 * UNIT, "R9 mode0");
        write_reg(1'b0, CFG_W'((0 << 2) | 3));
        sweep(0, 3, 4 * 4 * UNIT, "R9 len0");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule